// File: doc/BRIEF.md
# Transparent video RAM update controller

This block gives a CPU read and write access to display RAM without disturbing the picture. The CPU never addresses the RAM directly: it reads and writes a one-byte latch port, and the controller moves bytes between that port and the RAM. It does this only in update slots, and slots are placed only while the display is in horizontal or vertical blanking. The controller holds the update address, a write-pending flag, a write-data latch and a read-ahead latch.

Every slot that finds no write waiting reads the RAM at the update address, so the next CPU read can return at once. A CPU write to the latch port marks a write as pending. The next slot commits that byte, steps the address, and then starts a fresh read-ahead at the new address. A CPU read of the port returns the prefetched byte, steps the address and asks for the next read-ahead. The controller runs these slots only while its internal register select points at the transparent-update entry.

Top module: `tvu_top`

## Requirements
- R1: `updStrobe`, `memWeN` low and `latchOeN` low occur only in cycles where `blank` is high.
- R2: Slots run only while the register select holds 31. Writing 31 at offset 0 arms the block and requests a read-ahead at the current address. Writing any other value disarms it and drops the request. A pending write is kept, and it is committed after the block is armed again.
- R3: A slot drives the update address on `memAddr` and raises `updStrobe` for exactly one clock. No slot is placed in a cycle where `cpuCs` is high.
- R4: A slot taken with no write pending keeps `memWeN` and `latchOeN` high and captures `memRdData` into the read-ahead latch. A later CPU read at offset 3 returns that byte on `cpuRdData` during the access.
- R5: A CPU write at offset 3 stores the byte in the write latch, sets write-pending and requests a slot.
- R6: A slot taken with write-pending set drives `memWeN` and `latchOeN` low together for that single cycle, with the latched byte on `memWrData`.
- R7: Write-pending clears at the end of the write slot. The update address then steps by one, wrapping modulo 2^ADDR_W, and a read-ahead slot at the new address follows.
- R8: A CPU read at offset 3 steps the update address by one and requests a read-ahead slot.
- R9: Offset 0 writes take bits [4:0] as the register select. Offset 1 writes go to the selected entry: entry 18 loads the address bits above bit 7 from the low data bits, and entry 19 loads address bits [7:0]. Offset 1 writes to any other entry are ignored. Offsets 0 and 1 never touch the latches or start a slot, and reads at offsets 0, 1 and 2 return zero.
- R10: During a run of CPU reads, write-pending never sets and no RAM write occurs.
- R11: A synchronous reset clears the register select, the address, write-pending, the slot request and both latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous reset, active high |
| blank | input | 1 | High during horizontal or vertical blanking |
| cpuCs | input | 1 | CPU access in this cycle |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 2 | CPU port offset |
| cpuWrData | input | DATA_W | CPU write data |
| cpuRdData | output | DATA_W | CPU read data (read-ahead latch at offset 3, else zero) |
| memAddr | output | ADDR_W | Display RAM address (update address) |
| memWrData | output | DATA_W | Byte written to RAM |
| memRdData | input | DATA_W | RAM read data (asynchronous) |
| memWeN | output | 1 | RAM write enable, active low |
| latchOeN | output | 1 | Write latch output enable, active low |
| updStrobe | output | 1 | One-cycle update slot strobe |

## Verification
The hardest state to reach is a write that is left pending while the block is disarmed. That state must produce no slot even through long blanking, and it must still commit at the right address once the block is armed again. The bench gets there by deselecting the update entry, writing the latch, holding blanking high, and then writing 31 again. It also forces blanking low while a request waits, checks that nothing fires, and covers the address wrap at the top of the range. Random bursts of writes and reads run between these directed cases.

// File: rtl/tvu_pkg.sv
package tvu_pkg;
  localparam logic [1:0] OFS_SEL   = 2'd0;
  localparam logic [1:0] OFS_REG   = 2'd1;
  localparam logic [1:0] OFS_LATCH = 2'd3;

  localparam logic [4:0] SEL_ADDR_HI = 5'd18;
  localparam logic [4:0] SEL_ADDR_LO = 5'd19;
  localparam logic [4:0] SEL_XPARENT = 5'd31;

  typedef struct packed {
    logic loadHi;
    logic loadLo;
    logic latchWr;
    logic readCap;
    logic addrInc;
  } tvuStrobeT;
endpackage

// File: rtl/tvu_ctrl.sv
module tvu_ctrl
  import tvu_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            blank,
  input  logic            cpuCs,
  input  logic            cpuWe,
  input  logic [1:0]      cpuAddr,
  input  logic [4:0]      selData,
  output tvuStrobeT       strb,
  output logic            updStrobe,
  output logic            writeSlot,
  output logic            armed,
  output logic            writePend
);
  logic [4:0] regSel;
  logic       reqPend;
  logic       selWr, regWr, latWr, latRd;

  always_comb begin
    selWr = cpuCs && cpuWe && (cpuAddr == OFS_SEL);
    regWr = cpuCs && cpuWe && (cpuAddr == OFS_REG);
    latWr = cpuCs && cpuWe && (cpuAddr == OFS_LATCH);
    latRd = cpuCs && !cpuWe && (cpuAddr == OFS_LATCH);

    armed     = (regSel == SEL_XPARENT);
    // CPU traffic owns the cycle; a slot waits for a free one
    updStrobe = armed && blank && reqPend && !cpuCs;
    writeSlot = updStrobe && writePend;

    strb.loadHi  = regWr && (regSel == SEL_ADDR_HI);
    strb.loadLo  = regWr && (regSel == SEL_ADDR_LO);
    strb.latchWr = latWr;
    strb.readCap = updStrobe && !writePend;
    strb.addrInc = writeSlot || latRd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regSel    <= '0;
      writePend <= 1'b0;
      reqPend   <= 1'b0;
    end else begin
      if (selWr) regSel <= selData;

      if (latWr)          writePend <= 1'b1;
      else if (writeSlot) writePend <= 1'b0;

      // a write slot leaves the request set so a read-ahead follows
      if (selWr)               reqPend <= (selData == SEL_XPARENT);
      else if (latWr || latRd) reqPend <= 1'b1;
      else if (strb.readCap)   reqPend <= 1'b0;
    end
  end
endmodule

// File: rtl/tvu_datapath.sv
module tvu_datapath
  import tvu_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  tvuStrobeT         strb,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] updAddr,
  output logic [DATA_W-1:0] wrLatch,
  output logic [DATA_W-1:0] rdLatch
);
  localparam int HI_W = ADDR_W - DATA_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      updAddr <= '0;
      wrLatch <= '0;
      rdLatch <= '0;
    end else begin
      if (strb.addrInc)     updAddr <= updAddr + ADDR_W'(1);
      else if (strb.loadHi) updAddr[ADDR_W-1:DATA_W] <= cpuWrData[HI_W-1:0];
      else if (strb.loadLo) updAddr[DATA_W-1:0] <= cpuWrData;

      if (strb.latchWr) wrLatch <= cpuWrData;
      if (strb.readCap) rdLatch <= memRdData;
    end
  end
endmodule

// File: rtl/tvu_top.sv
module tvu_top
  import tvu_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              blank,
  input  logic              cpuCs,
  input  logic              cpuWe,
  input  logic [1:0]        cpuAddr,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic [DATA_W-1:0] cpuRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memWeN,
  output logic              latchOeN,
  output logic              updStrobe
);
  tvuStrobeT         strb;
  logic              writeSlot, armed, writePend;
  logic [ADDR_W-1:0] updAddr;
  logic [DATA_W-1:0] wrLatch, rdLatch;

  tvu_ctrl uCtrl (
    .clk(clk), .rst(rst), .blank(blank), .cpuCs(cpuCs), .cpuWe(cpuWe),
    .cpuAddr(cpuAddr), .selData(cpuWrData[4:0]), .strb(strb),
    .updStrobe(updStrobe), .writeSlot(writeSlot), .armed(armed),
    .writePend(writePend)
  );

  tvu_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rst(rst), .strb(strb), .cpuWrData(cpuWrData),
    .memRdData(memRdData), .updAddr(updAddr), .wrLatch(wrLatch),
    .rdLatch(rdLatch)
  );

  assign memAddr   = updAddr;
  assign memWrData = wrLatch;
  assign memWeN    = !writeSlot;
  assign latchOeN  = !writeSlot;
  assign cpuRdData = (cpuCs && !cpuWe && cpuAddr == OFS_LATCH) ? rdLatch : '0;
endmodule

// File: rtl/tvu_checker.sv
module tvu_checker #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              blank,
  input logic              cpuCs,
  input logic              cpuWe,
  input logic [1:0]        cpuAddr,
  input logic              updStrobe,
  input logic              memWeN,
  input logic              latchOeN,
  input logic [ADDR_W-1:0] memAddr,
  input logic              armed,
  input logic              writePend
);
  a_r1_blank_only: assert property (@(posedge clk) disable iff (rst)
    (updStrobe || !memWeN || !latchOeN) |-> blank);

  a_r2_disarmed_idle: assert property (@(posedge clk) disable iff (rst)
    !armed |-> !updStrobe);

  a_r3_cpu_first: assert property (@(posedge clk) disable iff (rst)
    updStrobe |-> !cpuCs);

  a_r5_latch_sets_pending: assert property (@(posedge clk) disable iff (rst)
    (cpuCs && cpuWe && cpuAddr == 2'd3) |=> writePend);

  a_r6_write_in_slot: assert property (@(posedge clk) disable iff (rst)
    !memWeN |-> (updStrobe && !latchOeN));

  a_r7_write_one_cycle: assert property (@(posedge clk) disable iff (rst)
    !memWeN |=> memWeN);

  a_r7_addr_step: assert property (@(posedge clk) disable iff (rst)
    !memWeN |=> (memAddr == ADDR_W'($past(memAddr) + 1'b1)));

  a_r10_read_keeps_clear: assert property (@(posedge clk) disable iff (rst)
    (cpuCs && !cpuWe && cpuAddr == 2'd3 && !writePend) |=> !writePend);
endmodule

bind tvu_top tvu_checker #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rst(rst), .blank(blank), .cpuCs(cpuCs), .cpuWe(cpuWe),
  .cpuAddr(cpuAddr), .updStrobe(updStrobe), .memWeN(memWeN),
  .latchOeN(latchOeN), .memAddr(memAddr), .armed(armed),
  .writePend(writePend)
);

// File: tb/sim_tvu_top.sv
module sim_tvu_top;
  localparam int CLK_P = 10;
  localparam int AW    = 11;
  localparam int DEPTH = 1 << AW;

  logic       clk, rst, blank, cpuCs, cpuWe, memWeN, latchOeN, updStrobe;
  logic [1:0] cpuAddr;
  logic [7:0] cpuWrData, cpuRdData, memWrData, memRdData;
  logic [AW-1:0] memAddr;

  logic [7:0] ram    [DEPTH];
  logic [7:0] expMem [DEPTH];

  int nChk = 0, nBad = 0, cyc = 0, blankMode = 1;
  bit inReadBurst = 0;

  tvu_top #(.ADDR_W(AW), .DATA_W(8)) u0 (
    .clk(clk), .rst(rst), .blank(blank), .cpuCs(cpuCs), .cpuWe(cpuWe),
    .cpuAddr(cpuAddr), .cpuWrData(cpuWrData), .cpuRdData(cpuRdData),
    .memAddr(memAddr), .memWrData(memWrData), .memRdData(memRdData),
    .memWeN(memWeN), .latchOeN(latchOeN), .updStrobe(updStrobe)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  assign memRdData = ram[memAddr];
  always @(posedge clk) if (!memWeN) ram[memAddr] <= memWrData;

  always @(negedge clk) begin
    cyc++;
    case (blankMode)
      0: blank = (cyc % 10) >= 6;
      1: blank = 1'b0;
      default: blank = 1'b1;
    endcase
  end

  function automatic int wrapA(int a);
    return a & (DEPTH - 1);
  endfunction

  function automatic logic [7:0] seedVal(int i);
    return 8'((i * 7) ^ 8'h3a);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  // port monitor: R1 enables only in blanking, R3 no slot during CPU access, R10 no writes in read runs
  always begin
    @(negedge clk);
    #1;
    if (!rst) begin
      if (updStrobe || !memWeN || !latchOeN) chk(blank === 1'b1, "R1", blank, 1);
      if (updStrobe) chk(!cpuCs, "R3", cpuCs, 0);
      if (inReadBurst) chk(memWeN === 1'b1, "R10", memWeN, 1);
    end
  end

  task automatic busWr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    cpuCs = 1; cpuWe = 1; cpuAddr = a; cpuWrData = d;
    @(negedge clk);
    cpuCs = 0; cpuWe = 0;
    #1;
  endtask

  task automatic busRd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cpuCs = 1; cpuWe = 0; cpuAddr = a;
    #1 d = cpuRdData;
    @(negedge clk);
    cpuCs = 0;
    #1;
  endtask

  task automatic waitSlot(bit expWr, int expAddr, int expData, string req);
    int n = 0;
    while (!updStrobe && n < 300) begin
      @(negedge clk); #1; n++;
    end
    if (!updStrobe) chk(0, req, 0, 1);
    else begin
      chk(!memWeN == expWr, req, !memWeN, expWr);
      chk(!latchOeN == expWr, req, !latchOeN, expWr);
      chk(memAddr == wrapA(expAddr), req, memAddr, wrapA(expAddr));
      if (expWr) chk(memWrData == 8'(expData), req, memWrData, expData);
    end
    @(negedge clk); #1;
  endtask

  task automatic noSlot(int cycles, string req);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk); #1;
      if (updStrobe || !memWeN) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic setAddr(int a);
    busWr(2'd0, 8'd18); busWr(2'd1, 8'(wrapA(a) >> 8));
    busWr(2'd0, 8'd19); busWr(2'd1, 8'(wrapA(a)));
    busWr(2'd0, 8'd31);
    waitSlot(0, a, 0, "R2");
  endtask

  initial begin
    #(CLK_P * 150000);
    nBad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    summary();
  end

  initial begin
    logic [7:0] v;
    int start, len;
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) begin ram[i] = seedVal(i); expMem[i] = seedVal(i); end
    rst = 1; cpuCs = 0; cpuWe = 0; cpuAddr = 0; cpuWrData = 0; blank = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R11 reset state
    chk(memWeN && latchOeN && !updStrobe, "R11", {memWeN, latchOeN, updStrobe}, 3'b110);
    chk(memAddr == 0, "R11", memAddr, 0);
    busRd(2'd3, v);
    chk(v == 0, "R11", v, 0);
    busWr(2'd0, 8'd19); busWr(2'd1, 8'd0);

    // R1: armed request waits while blanking is low
    busWr(2'd0, 8'd31);
    noSlot(40, "R1");
    blankMode = 0;
    waitSlot(0, 0, 0, "R1");
    busRd(2'd3, v);
    chk(v == expMem[0], "R4", v, expMem[0]);
    waitSlot(0, 1, 0, "R8");

    // random write bursts then read bursts
    for (int b = 0; b < 4; b++) begin
      start = int'($urandom % DEPTH);
      len = 3 + int'($urandom % 6);
      setAddr(start);
      for (int i = 0; i < len; i++) begin
        v = 8'($urandom);
        busWr(2'd3, v);
        expMem[wrapA(start + i)] = v;
        waitSlot(1, start + i, v, "R6");
        waitSlot(0, start + i + 1, 0, "R7");
      end
      inReadBurst = 1;
      setAddr(start);
      for (int i = 0; i < len; i++) begin
        busRd(2'd3, v);
        chk(v == expMem[wrapA(start + i)], "R10", v, expMem[wrapA(start + i)]);
        waitSlot(0, start + i + 1, 0, "R8");
      end
      inReadBurst = 0;
    end

    // R7 wrap at top of address range
    setAddr(DEPTH - 1);
    busWr(2'd3, 8'ha5);
    expMem[DEPTH - 1] = 8'ha5;
    waitSlot(1, DEPTH - 1, 8'ha5, "R7");
    waitSlot(0, 0, 0, "R7");

    // R9 offsets 0/1 leave latches and slots alone
    blankMode = 2;
    busWr(2'd1, 8'h3c);
    noSlot(30, "R9");
    busRd(2'd0, v); chk(v == 0, "R9", v, 0);
    busRd(2'd1, v); chk(v == 0, "R9", v, 0);
    busRd(2'd2, v); chk(v == 0, "R9", v, 0);
    busRd(2'd3, v); chk(v == expMem[0], "R9", v, expMem[0]);
    waitSlot(0, 1, 0, "R8");

    // R2 disarmed with a pending write, then rearmed
    busWr(2'd0, 8'd5);
    busWr(2'd3, 8'h5a);
    noSlot(40, "R2");
    expMem[1] = 8'h5a;
    busWr(2'd0, 8'd31);
    waitSlot(1, 1, 8'h5a, "R2");
    waitSlot(0, 2, 0, "R2");

    // R11 reset drops a pending write
    blankMode = 1;
    busWr(2'd3, 8'h77);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    #1;
    chk(memAddr == 0, "R11", memAddr, 0);
    blankMode = 2;
    busWr(2'd0, 8'd31);
    waitSlot(0, 0, 0, "R11");
    blankMode = 0;

    // R6 whole-RAM comparison
    begin
      int diff = 0;
      for (int i = 0; i < DEPTH; i++) if (ram[i] !== expMem[i]) diff++;
      chk(diff == 0, "R6", diff, 0);
    end
    summary();
  end
endmodule